// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block is the system-wide interrupt concentrator of a multiprocessor. It watches 32 device interrupt lines and one local-timer line per processor, records their changes in a master pending word, and combines that word with a disable word. The disable word has a global off switch in its top bit. Each source that is both pending and enabled is translated into a processor interrupt level (PIL) through a parameter table of 32 four-bit entries. The resulting level set goes to exactly one processor, chosen by software. Every processor also gets its own software-interrupt requests merged in, whatever the routing state. The outputs are one registered 16-bit level-request vector per processor.

Software reaches the block over a plain word-addressed bus with a write strobe. Offsets 0 and 1 read back the pending and disable words. Offsets 2 and 3 enable or disable sources, and disabling a source also drops its pending bit. Offset 4 selects the target processor. A fixed reserved-mask parameter names the sources that can never be enabled. The processor-side registers that hold the software-interrupt bits sit outside this block and arrive as inputs.

Top module: `irq_router_top`

## Requirements
- R1: While reset is high, every PIL output is zero. Reset leaves the pending word zero, the disable word equal to the reserved mask (default 32'h0FA2007F), and the target processor at 0. Right after reset, a read at offset 1 returns 0.
- R2: A read presents its data on `rdata` one cycle after `addr` is set. Offset 0 returns the pending word with bit 31 forced to 0. Offsets other than 0 and 1 return 0.
- R3: A read at offset 1 returns the disable word ANDed with the valid mask, which is the complement of the reserved mask. The reserved bits of the disable word never change.
- R4: A write at offset 2 clears the disable bits selected by the written data ANDed with the valid mask.
- R5: A write at offset 3 sets the disable bits selected by the written data ANDed with the valid mask, and clears the same bits of the pending word. A cleared bit stays clear until its input changes level again. A write wins over an input change in the same cycle.
- R6: A write at offset 4 sets the target processor to the written value modulo N_CPU, where N_CPU is a power of two. Device levels then appear on that processor only.
- R7: When device line j changes level, pending bit j takes the new level.
- R8: When the timer line of any processor changes level, pending bit TIMER_BIT (default 19) takes the new level.
- R9: While disable bit 31 is set, no device level reaches any processor. Only software requests appear on the outputs.
- R10: Each bit j that is pending and not disabled sets PIL bit LVL_MAP[j] on the target processor. The default table gives entry j the value (j mod 15)+1. Reserved sources are never routed.
- R11: Processor c's PIL vector is ORed with bits 31:17 of its software word, shifted down by 16. Bits 16:0 of the software word have no effect. This holds for every processor, whatever the target or disable state.
- R12: The PIL outputs are registered. A device-line change reaches the PIL outputs on the second clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | 32 | Device interrupt levels |
| tmr_irq | input | N_CPU | Per-processor local timer levels |
| soft_word | input | 32*N_CPU | Per-processor software interrupt words, processor c at [32c+31:32c] |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pil_req | output | 16*N_CPU | Registered level requests, processor c at [16c+15:16c] |

## Verification
The write-side assertions assume that the write strobe is high for exactly one cycle per access. They also assume that `addr` and `wdata` are stable while it is high. The bench meets this by driving all bus inputs at the falling edge and dropping the strobe one cycle later. The output assertions compare each PIL vector with the software word of the previous cycle, so they assume that software words change only at falling edges, which the stimulus also respects. Input lines change only between bus accesses, so each change can be traced to a single edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 32;
  localparam int NLVL = 16;
  localparam int LVLW = $clog2(NLVL);
  localparam int WW   = 32;
  localparam int AW   = 3;
  localparam int GLOBAL_BIT = WW - 1;
  localparam logic [WW-1:0] SOFT_MASK = 32'hFFFE_0000;

  typedef enum logic [AW-1:0] {
    OFF_PEND    = 3'd0,
    OFF_MASK    = 3'd1,
    OFF_UNMASK  = 3'd2,
    OFF_MASKSET = 3'd3,
    OFF_TARGET  = 3'd4
  } reg_off_e;

  typedef logic [NSRC-1:0][LVLW-1:0] lvl_map_t;

  // Default source-to-level table: levels 1..15 repeating.
  function automatic lvl_map_t default_map();
    lvl_map_t m;
    for (int j = 0; j < NSRC; j++) m[j] = LVLW'((j % 15) + 1);
    return m;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int TIMER_BIT = 19,
  parameter logic [WW-1:0] RSVD = 32'h0FA2_007F,
  localparam int CPUW = $clog2(N_CPU)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  dev_irq,
  input  logic [N_CPU-1:0] tmr_irq,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WW-1:0]    wdata,
  output logic [WW-1:0]    rdata,
  output logic [WW-1:0]    pend_q,
  output logic [WW-1:0]    dis_q,
  output logic [CPUW-1:0]  target_q
);
  localparam logic [WW-1:0] VALID = ~RSVD;

  logic [NSRC-1:0]  dev_q;
  logic [N_CPU-1:0] tmr_q;
  logic [WW-1:0]    pend_d, dis_d, rdata_d, wsel;
  logic [CPUW-1:0]  tgt_d;

  assign wsel = wdata & VALID;

  always_comb begin
    pend_d = pend_q;
    for (int j = 0; j < NSRC; j++)
      if (dev_irq[j] != dev_q[j]) pend_d[j] = dev_irq[j];
    for (int c = 0; c < N_CPU; c++)
      if (tmr_irq[c] != tmr_q[c]) pend_d[TIMER_BIT] = tmr_irq[c];
    dis_d = dis_q;
    tgt_d = target_q;
    if (we) begin
      case (reg_off_e'(addr))
        OFF_UNMASK:  dis_d = dis_q & ~wsel;
        OFF_MASKSET: begin
          dis_d  = dis_q | wsel;
          pend_d = pend_d & ~wsel;
        end
        OFF_TARGET:  tgt_d = wdata[CPUW-1:0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (reg_off_e'(addr))
      OFF_PEND: rdata_d = pend_q & ~(WW'(1) << GLOBAL_BIT);
      OFF_MASK: rdata_d = dis_q & VALID;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q    <= '0;
      tmr_q    <= '0;
      pend_q   <= '0;
      dis_q    <= RSVD;
      target_q <= '0;
      rdata    <= '0;
    end else begin
      dev_q    <= dev_irq;
      tmr_q    <= tmr_irq;
      pend_q   <= pend_d;
      dis_q    <= dis_d;
      target_q <= tgt_d;
      rdata    <= rdata_d;
    end
  end

  assert_maskset_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 3'd3) |=> ((pend_q & $past(wsel)) == '0 && (dis_q & $past(wsel)) == $past(wsel)));
  assert_unmask_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 3'd2) |=> ((dis_q & $past(wsel)) == '0));
  assert_target_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == 3'd4) |=> $stable(target_q));
  assert_rsvd_stable_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(dis_q & RSVD));
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
#(
  parameter lvl_map_t MAP = default_map()
) (
  input  logic [NSRC-1:0] eff,
  output logic [NLVL-1:0] lvl_vec
);
  logic [NSRC-1:0][NLVL-1:0] contrib;

  for (genvar j = 0; j < NSRC; j++) begin : g_src
    assign contrib[j] = eff[j] ? (NLVL'(1) << MAP[j]) : '0;
  end

  always_comb begin
    lvl_vec = '0;
    for (int j = 0; j < NSRC; j++) lvl_vec = lvl_vec | contrib[j];
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_pkg::*;
#(
  parameter int CPU_ID = 0,
  parameter int CPUW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            route_on,
  input  logic [CPUW-1:0] target,
  input  logic [NLVL-1:0] dev_lvl,
  input  logic [WW-1:0]   soft_word,
  output logic [NLVL-1:0] pil_q
);
  logic [NLVL-1:0] soft16, pil_d;
  logic [WW-1:0]   soft_sel;
  logic            mine;

  assign soft_sel = (soft_word & SOFT_MASK) >> NLVL;
  assign soft16   = soft_sel[NLVL-1:0];
  assign mine     = route_on && (target == CPUW'(CPU_ID));
  assign pil_d    = (mine ? dev_lvl : '0) | soft16;

  always_ff @(posedge clk) begin
    if (rst) pil_q <= '0;
    else     pil_q <= pil_d;
  end

  assert_gated_soft_only_R9: assert property (@(posedge clk) disable iff (rst)
    !route_on |=> (pil_q == $past(soft16)));
  assert_nontarget_soft_R11: assert property (@(posedge clk) disable iff (rst)
    (target != CPUW'(CPU_ID)) |=> (pil_q == $past(soft16)));
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int TIMER_BIT = 19,
  parameter logic [WW-1:0] RSVD = 32'h0FA2_007F,
  parameter lvl_map_t LVL_MAP = default_map(),
  localparam int CPUW = $clog2(N_CPU)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       dev_irq,
  input  logic [N_CPU-1:0]      tmr_irq,
  input  logic [N_CPU*WW-1:0]   soft_word,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [WW-1:0]         wdata,
  output logic [WW-1:0]         rdata,
  output logic [N_CPU*NLVL-1:0] pil_req
);
  logic [WW-1:0]   pend_q, dis_q, eff;
  logic [CPUW-1:0] target_q;
  logic [NLVL-1:0] dev_lvl;
  logic            route_on;

  irq_regs #(.N_CPU(N_CPU), .TIMER_BIT(TIMER_BIT), .RSVD(RSVD)) u_regs (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .tmr_irq(tmr_irq),
    .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pend_q(pend_q), .dis_q(dis_q), .target_q(target_q)
  );

  assign eff      = pend_q & ~dis_q;
  assign route_on = (|eff) && !dis_q[GLOBAL_BIT];

  irq_level_map #(.MAP(LVL_MAP)) u_map (.eff(eff), .lvl_vec(dev_lvl));

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    irq_cpu_port #(.CPU_ID(c), .CPUW(CPUW)) u_port (
      .clk(clk), .rst(rst), .route_on(route_on), .target(target_q),
      .dev_lvl(dev_lvl), .soft_word(soft_word[c*WW +: WW]),
      .pil_q(pil_req[c*NLVL +: NLVL])
    );
  end

  assert_global_off_R9: assert property (@(posedge clk) disable iff (rst)
    dis_q[GLOBAL_BIT] |-> !route_on);
endmodule

// File: tb/irq_router_top_test.sv
module irq_router_top_test;
  localparam int NC = 4;

  logic clk = 0, rst = 1, we = 0;
  logic [31:0] dev_irq = '0, wdata = '0, rdata;
  logic [NC-1:0] tmr_irq = '0;
  logic [NC*32-1:0] soft_word = '0;
  logic [2:0] addr = '0;
  logic [NC*16-1:0] pil_req;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_router_top uut (.clk(clk), .rst(rst), .dev_irq(dev_irq), .tmr_irq(tmr_irq),
    .soft_word(soft_word), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pil_req(pil_req));

  function automatic logic [15:0] lvl_bit(int j);
    return 16'(1) << ((j % 15) + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] pil(int c);
    return {16'h0, pil_req[c*16 +: 16]};
  endfunction

  // {is_read, addr, data, expected read}
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h0,         32'h0},
    {1'b1, 3'd0, 32'h0,         32'h0},
    {1'b0, 3'd3, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 3'd1, 32'h0,         32'hF05D_FF80},
    {1'b0, 3'd2, 32'h0000_FF00, 32'h0},
    {1'b1, 3'd1, 32'h0,         32'hF05D_0080},
    {1'b0, 3'd2, 32'hF000_0000, 32'h0},
    {1'b1, 3'd1, 32'h0,         32'h005D_0080},
    {1'b1, 3'd5, 32'h0,         32'h0},
    {1'b0, 3'd2, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 3'd1, 32'h0,         32'h0},
    {1'b0, 3'd4, 32'h0000_0007, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R1 pil in reset", pil(c), 0);
    rst = 0;
    // Table: R1 reset readback, R2 read offsets, R3/R4 mask masking, R6 target write
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) rd("R3 table read", VEC[i][66:64], VEC[i][31:0]);
      else wr(VEC[i][66:64], VEC[i][63:32]);
    end
    // Target now 3 (7 mod 4). R12 timing and R10 mapping.
    dev_irq[8] = 1;
    @(negedge clk);
    chk("R12 one edge", pil(3), 0);
    @(negedge clk);
    chk("R12 two edges", pil(3), lvl_bit(8));
    chk("R10 non-target", pil(0), 0);
    rd("R7 pending", 3'd0, 32'h100);
    dev_irq[0] = 1; settle();
    rd("R7 reserved pending", 3'd0, 32'h101);
    chk("R10 reserved not routed", pil(3), lvl_bit(8));
    dev_irq[31] = 1; settle();
    rd("R2 bit31 hidden", 3'd0, 32'h101);
    chk("R10 bit31 routed", pil(3), lvl_bit(8) | lvl_bit(31));
    wr(3'd3, 32'h8000_0000); settle();
    chk("R9 global off", pil(3), 0);
    rd("R3 global bit", 3'd1, 32'h8000_0000);
    wr(3'd2, 32'h8000_0000); settle();
    chk("R5 pend31 cleared, R9 resumed", pil(3), lvl_bit(8));
    wr(3'd3, 32'h100);
    rd("R5 pending cleared", 3'd0, 32'h001);
    wr(3'd2, 32'h100); settle();
    chk("R5 stays cleared", pil(3), 0);
    rd("R4 all enabled", 3'd1, 0);
    wr(3'd4, 32'd5);
    dev_irq[7] = 1; settle();
    chk("R6 new target", pil(1), lvl_bit(7));
    chk("R6 old target", pil(3), 0);
    soft_word[2*32 +: 32] = 32'hC002_FFFF; settle();
    chk("R11 soft merged", pil(2), 32'hC002);
    chk("R11 target unaffected", pil(1), lvl_bit(7));
    soft_word[3*32 +: 32] = 32'h0001_FFFF; settle();
    chk("R11 low soft bits ignored", pil(3), 0);
    tmr_irq[2] = 1; settle();
    chk("R8 timer routed", pil(1), lvl_bit(7) | lvl_bit(19));
    rd("R8 timer pending", 3'd0, 32'h0008_0081);
    tmr_irq[2] = 0; settle();
    rd("R8 timer cleared", 3'd0, 32'h81);
    dev_irq[7] = 0; settle();
    chk("R7 line dropped", pil(1), 0);
    chk("R11 soft kept", pil(2), 32'hC002);
    // Reset in mid-run
    dev_irq = '0; soft_word = '0; settle();
    rst = 1; settle();
    chk("R1 pil reset", pil(2), 0);
    rst = 0;
    rd("R1 pending reset", 3'd0, 0);
    rd("R1 mask reset", 3'd1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule